// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block walks a clock generator into and out of its low-power state. A power-down request arrives as an asynchronous, active-low level. The block first passes it through a synchronizer and confirms it for one more cycle. It then asks every output clock group to park low and waits until all of them report that they are held. Only after that does it switch off the VCO and the crystal oscillator.

The groups are CPU, PCI, AGP, SDRAM, the 14.318 MHz reference and the 48 MHz output. The reference and 48 MHz groups take more cycles to park than the others, so the oscillator switch-off waits for the slowest group.

When the request is released, the crystal oscillator is enabled first and the VCO one cycle later. A programmable stabilization count then runs, and after it every group is released in the same cycle. With the default count the wake-up path is under 70 reference cycles, far inside a 3 ms budget.

A mode strap is captured while reset is high. A captured 1 disables the power-down function for the rest of operation.

Top module: `pd_clock_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, all `hold_low` bits are 0, `vco_en` and `xtal_en` are 1, and `park_done` is 0.
- R2: `pd_req_n` passes through a two-flop synchronizer and must then still be low one cycle later. After a falling edge of `pd_req_n` ahead of clock edge 1, no hold bit is set before edge 5. A low pulse lasting one cycle never starts parking.
- R3: Once parking starts, each group's hold bit rises after its own park latency and then stays high. Bits 0 to 3 (CPU, PCI, AGP, SDRAM) take 1 cycle, bit 5 (48 MHz) takes 2 cycles and bit 4 (reference) takes 3 cycles. With R2's timing this means edges 5, 6 and 7.
- R4: `vco_en` is 0 only while all hold bits are 1, and `xtal_en` is 0 only while `vco_en` is 0. Both drop together on the cycle after the last group parks.
- R5: `park_done` is 1 exactly when every hold bit is 1. The oscillators are switched off only after `park_done` has been seen high.
- R6: After `pd_req_n` returns high, the synchronized release re-enables `xtal_en` one cycle before `vco_en`. All hold bits stay high through both cycles.
- R7: After `vco_en` returns, all hold bits remain high for STAB_CYCLES (default 64) more cycles and then clear in the same cycle.
- R8: When `mode_strap` is 1 during reset, `pd_req_n` has no effect: holds stay 0 and both enables stay 1. Changes on `mode_strap` after reset have no effect.
- R9: Once parking has started, raising `pd_req_n` does not abort it. The sequence still parks every group and switches both oscillators off before it wakes up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| mode_strap | input | 1 | Mode strap; 0 enables power-down |
| hold_low | output | 6 | Per-group hold-low controls: bit0 CPU, bit1 PCI, bit2 AGP, bit3 SDRAM, bit4 reference, bit5 48 MHz |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| park_done | output | 1 | All groups are parked low |

## Verification
The sequence is driven with a one-cycle glitch on the request, which separates a real synchronize-and-confirm path from a bare edge detector. A clean long request checks the staggered group park times and the gap between the last park and the oscillator switch-off. A request withdrawn in mid-park shows whether the sequence can be aborted before it completes. A run with the strap set high during reset and cleared afterwards shows that the function is gated by the captured strap and not by the live pin.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    localparam int NUM_GROUPS = 6;
    localparam int GRP_REF    = 4;
    localparam int GRP_USB    = 5;

    typedef enum logic [2:0] {
        SEQ_RUN     = 3'd0,
        SEQ_SYNC    = 3'd1,
        SEQ_PARK    = 3'd2,
        SEQ_OSC_OFF = 3'd3,
        SEQ_OSC_ON  = 3'd4,
        SEQ_WAIT    = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic xtal_en;
        logic vco_en;
        logic park_req;
    } seq_ctrl_t;

    // Decode the control word that each sequencer state drives.
    function automatic seq_ctrl_t ctrl_of(seq_state_t s);
        seq_ctrl_t c;
        c.park_req = (s == SEQ_PARK) || (s == SEQ_OSC_OFF) ||
                     (s == SEQ_OSC_ON) || (s == SEQ_WAIT);
        c.vco_en   = !((s == SEQ_OSC_OFF) || (s == SEQ_OSC_ON));
        c.xtal_en  = (s != SEQ_OSC_OFF);
        return c;
    endfunction

    // Number of cycles each group needs to park low.
    function automatic int park_cycles(int g, int ref_cyc, int usb_cyc);
        if (g == GRP_REF) return ref_cyc;
        if (g == GRP_USB) return usb_cyc;
        return 1;
    endfunction

endpackage

// File: rtl/pd_req_sync.sv
module pd_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_n};
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/pd_group_park.sv
module pd_group_park #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic park_req,
    output logic parked
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !park_req) begin
            cnt    <= '0;
            parked <= 1'b0;
        end else if (!parked) begin
            if (cnt == LAST) parked <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import pd_seq_pkg::*;
#(
    parameter int STAB_CYCLES = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_low,
    input  logic      pd_allowed,
    input  logic      all_parked,
    output seq_ctrl_t ctrl
);
    localparam int WCW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES);
    localparam logic [WCW-1:0] WLAST = WCW'(STAB_CYCLES - 1);

    seq_state_t st, nxt;
    logic [WCW-1:0] wcnt;

    always_comb begin
        nxt = st;
        case (st)
            SEQ_RUN:     if (pd_allowed && req_low) nxt = SEQ_SYNC;
            SEQ_SYNC:    nxt = req_low ? SEQ_PARK : SEQ_RUN;
            SEQ_PARK:    if (all_parked) nxt = SEQ_OSC_OFF;
            SEQ_OSC_OFF: if (!req_low) nxt = SEQ_OSC_ON;
            SEQ_OSC_ON:  nxt = SEQ_WAIT;
            SEQ_WAIT:    if (wcnt == WLAST) nxt = SEQ_RUN;
            default:     nxt = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SEQ_RUN;
            wcnt <= '0;
        end else begin
            st   <= nxt;
            wcnt <= (st == SEQ_WAIT) ? wcnt + 1'b1 : '0;
        end
    end

    assign ctrl = ctrl_of(st);
endmodule

// File: rtl/pd_clock_sequencer.sv
module pd_clock_sequencer
    import pd_seq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int STAB_CYCLES  = 64,
    parameter int REF_PARK_CYC = 3,
    parameter int USB_PARK_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pd_req_n,
    input  logic                  mode_strap,
    output logic [NUM_GROUPS-1:0] hold_low,
    output logic                  xtal_en,
    output logic                  vco_en,
    output logic                  park_done
);
    logic      strap_q;
    logic      pd_allowed;
    logic      req_sync_n;
    seq_ctrl_t ctrl;

    // Strap is captured only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) strap_q <= mode_strap;
    end
    assign pd_allowed = ~strap_q;

    pd_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (pd_req_n),
        .sync_n  (req_sync_n)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pd_group_park #(
            .LAT (park_cycles(g, REF_PARK_CYC, USB_PARK_CYC))
        ) u_park (
            .clk      (clk),
            .rst      (rst),
            .park_req (ctrl.park_req),
            .parked   (hold_low[g])
        );
    end

    assign park_done = &hold_low;

    pd_seq_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_low    (~req_sync_n),
        .pd_allowed (pd_allowed),
        .all_parked (park_done),
        .ctrl       (ctrl)
    );

    assign xtal_en = ctrl.xtal_en;
    assign vco_en  = ctrl.vco_en;
endmodule

// File: rtl/pd_clock_sequencer_chk.sv
module pd_clock_sequencer_chk
    import pd_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_GROUPS-1:0] hold_low,
    input logic                  xtal_en,
    input logic                  vco_en,
    input logic                  park_done,
    input logic                  pd_allowed
);
    assert_vco_off_parked_R4: assert property (@(posedge clk) disable iff (rst)
        !vco_en |-> (&hold_low));

    assert_xtal_off_vco_off_R4: assert property (@(posedge clk) disable iff (rst)
        !xtal_en |-> !vco_en);

    assert_done_before_off_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(vco_en) |-> $past(park_done));

    assert_xtal_first_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(vco_en) |-> ($past(xtal_en) && (&hold_low)));

    assert_release_together_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(&hold_low) && !(&hold_low)) |-> (hold_low == '0 && vco_en && xtal_en));

    assert_strap_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        !pd_allowed |-> (hold_low == '0 && vco_en && xtal_en));
endmodule

bind pd_clock_sequencer pd_clock_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_low   (hold_low),
    .xtal_en    (xtal_en),
    .vco_en     (vco_en),
    .park_done  (park_done),
    .pd_allowed (pd_allowed)
);

// File: tb/pd_clock_sequencer_test.sv
module pd_clock_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int STAB       = 64;
    localparam int NG         = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          pd_req_n;
    logic          mode_strap;
    logic [NG-1:0] hold_low;
    logic          xtal_en, vco_en, park_done;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    pd_clock_sequencer uut (
        .clk        (clk),
        .rst        (rst),
        .pd_req_n   (pd_req_n),
        .mode_strap (mode_strap),
        .hold_low   (hold_low),
        .xtal_en    (xtal_en),
        .vco_en     (vco_en),
        .park_done  (park_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: phase 0 run, 1 confirm, 2 park, 3 off, 4 xtal up, 5 settle.
    int m_s1, m_s2, m_strap, m_ph, m_wc;
    int m_cnt [NG];
    int lat   [NG] = '{1, 1, 1, 1, 3, 2};
    int park_old, all_old;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_strap = int'(mode_strap); m_ph = 0; m_wc = 0;
            for (int g = 0; g < NG; g++) m_cnt[g] = 0;
        end else begin
            park_old = (m_ph >= 2) ? 1 : 0;
            all_old  = 1;
            for (int g = 0; g < NG; g++) if (m_cnt[g] < lat[g]) all_old = 0;
            for (int g = 0; g < NG; g++) begin
                if (park_old == 0)         m_cnt[g] = 0;
                else if (m_cnt[g] < lat[g]) m_cnt[g] = m_cnt[g] + 1;
            end
            case (m_ph)
                0: if (m_strap == 0 && m_s2 == 0) m_ph = 1;
                1: m_ph = (m_s2 == 0) ? 2 : 0;
                2: if (all_old == 1) m_ph = 3;
                3: if (m_s2 == 1) m_ph = 4;
                4: begin m_ph = 5; m_wc = 0; end
                default: if (m_wc == STAB - 1) m_ph = 0; else m_wc = m_wc + 1;
            endcase
            m_s2 = m_s1;
            m_s1 = int'(pd_req_n);
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    logic [NG-1:0] e_hold;
    always @(negedge clk) begin
        if (!done_flag) begin
            for (int g = 0; g < NG; g++) e_hold[g] = (m_cnt[g] >= lat[g]);
            chk("R3 hold_low vs model", 32'(hold_low), 32'(e_hold));
            chk("R5 park_done vs model", 32'(park_done), 32'(&e_hold));
            chk("R4 vco_en vs model", 32'(vco_en), 32'((m_ph == 3 || m_ph == 4) ? 0 : 1));
            chk("R6 xtal_en vs model", 32'(xtal_en), 32'((m_ph == 3) ? 0 : 1));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1; mode_strap = strap; pd_req_n = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; pd_req_n = 1'b1; mode_strap = 1'b0;
        @(negedge clk);
        chk("R1 reset hold", 32'(hold_low), 32'h0);
        do_reset(1'b0);
        chk("R1 post-reset hold", 32'(hold_low), 32'h0);
        chk("R1 post-reset vco", 32'(vco_en), 32'h1);
        chk("R1 post-reset xtal", 32'(xtal_en), 32'h1);
        chk("R1 post-reset done", 32'(park_done), 32'h0);

        // R2: one-cycle glitch is rejected
        step(2);
        pd_req_n = 1'b0; step(1); pd_req_n = 1'b1;
        step(8);
        chk("R2 glitch no hold", 32'(hold_low), 32'h0);
        chk("R2 glitch vco", 32'(vco_en), 32'h1);

        // Full entry
        pd_req_n = 1'b0;
        step(4); chk("R2 no hold before edge 5", 32'(hold_low), 32'h0);
        step(1); chk("R3 fast groups at edge 5", 32'(hold_low), 32'h0F);
        step(1); chk("R3 48MHz at edge 6", 32'(hold_low), 32'h2F);
        step(1); chk("R3 reference at edge 7", 32'(hold_low), 32'h3F);
        chk("R5 done at edge 7", 32'(park_done), 32'h1);
        chk("R4 vco still on at edge 7", 32'(vco_en), 32'h1);
        step(1); chk("R4 vco off at edge 8", 32'(vco_en), 32'h0);
        chk("R4 xtal off at edge 8", 32'(xtal_en), 32'h0);
        step(10);
        chk("R4 still off", 32'(vco_en | xtal_en), 32'h0);

        // Exit
        pd_req_n = 1'b1;
        step(3); chk("R6 xtal first", 32'(xtal_en), 32'h1);
        chk("R6 vco still off", 32'(vco_en), 32'h0);
        chk("R6 holds kept", 32'(hold_low), 32'h3F);
        step(1); chk("R6 vco back", 32'(vco_en), 32'h1);
        step(64); chk("R7 holds through settle", 32'(hold_low), 32'h3F);
        step(1); chk("R7 release together", 32'(hold_low), 32'h0);

        // R9: withdraw request mid-park
        step(5);
        pd_req_n = 1'b0; step(4); pd_req_n = 1'b1;
        step(3); chk("R9 parked despite withdraw", 32'(hold_low), 32'h3F);
        step(1); chk("R9 oscillators off", 32'(vco_en | xtal_en), 32'h0);
        step(1); chk("R9 xtal restarts", 32'(xtal_en), 32'h1);
        step(70); chk("R9 returned to run", 32'(hold_low), 32'h0);

        // R8: strap high during reset blocks power-down
        do_reset(1'b1);
        mode_strap = 1'b0;
        pd_req_n = 1'b0;
        step(20);
        chk("R8 strap blocks hold", 32'(hold_low), 32'h0);
        chk("R8 strap keeps vco", 32'(vco_en), 32'h1);
        chk("R8 strap keeps xtal", 32'(xtal_en), 32'h1);
        pd_req_n = 1'b1;

        // R8: strap low at reset, high afterwards, still works
        do_reset(1'b0);
        mode_strap = 1'b1;
        pd_req_n = 1'b0;
        step(8); chk("R8 late strap ignored", 32'(vco_en), 32'h0);
        pd_req_n = 1'b1;
        step(80); chk("R8 recovery", 32'(hold_low), 32'h0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule